// File: doc/BRIEF.md
# Fault-Table Diagnosis Engine

This block turns a pass/fail record from a finished test run into a diagnosis. It holds a table with one row per modelled fault and one column per test pattern. A 1 in row i, column j means test j catches fault i. Software or a test controller fills the table through a row write port. It then presents the observed response vector, with bit j set when test j failed, and pulses a start strobe.

The engine walks the table one row per clock. It marks every row that equals the response in all columns and counts those rows. It then returns a verdict:
- a single fault located, together with its index;
- a group of faults that the test set cannot tell apart, given by the match mask;
- no matching row, so no diagnosis is possible;
- an all-zero response, meaning no fault was seen.

A busy level covers the whole scan, and a one-cycle done pulse closes it. The results stay readable until the next accepted start.

Top module: `fault_table_diag`

## Requirements
- R1: When `busy` is low and `tbl_wr_en` is high at a clock edge, row `tbl_wr_addr` takes the value `tbl_wr_row` (bit j = test j). A write presented while `busy` is high changes no row.
- R2: A start seen at an edge while `busy` is low is accepted, and `busy` is high from the next cycle. Rows are compared one per cycle, in order 0 to NUM_FAULTS-1. `busy` falls and `done` is high for exactly one cycle NUM_FAULTS+1 edges after the accepting edge.
- R3: A start presented while `busy` is high is ignored: the response already captured is kept and the scan is not restarted.
- R4: Bit i of `match_mask` is set when row i equals the captured response in every column. `match_count` always equals the number of set bits in `match_mask`.
- R5: With a nonzero response and exactly one matching row, `verdict` is 2'b01 and `located_idx` is that row's index.
- R6: With a nonzero response and two or more matching rows, `verdict` is 2'b10, every matching row is set in `match_mask`, and `located_idx` is 0.
- R7: With a nonzero response and no matching row, `verdict` is 2'b11 and `match_mask` is 0.
- R8: An all-zero response gives `verdict` 2'b00 whatever rows match. `match_mask` still lists the all-zero rows.
- R9: `verdict`, `located_idx`, `match_mask` and `match_count` are cleared to zero at an accepted start. They then hold their final values from the `done` cycle until the next accepted start.
- R10: After reset `busy`, `done`, `verdict`, `located_idx`, `match_mask` and `match_count` are all zero, and every table row is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Table row write strobe |
| tbl_wr_addr | input | clog2(NUM_FAULTS) | Row (fault) being written |
| tbl_wr_row | input | NUM_TESTS | Detection bits of that fault, bit j = test j |
| start | input | 1 | Begin a diagnosis of `response` |
| response | input | NUM_TESTS | Observed fail bits, bit j = test j failed |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when the verdict is ready |
| verdict | output | 2 | 00 no fault seen, 01 located, 10 indistinguishable, 11 no match |
| located_idx | output | clog2(NUM_FAULTS) | Index of the located fault |
| match_mask | output | NUM_FAULTS | Rows equal to the response |
| match_count | output | clog2(NUM_FAULTS+1) | Number of matching rows |

## Verification
The bench loads a table that has a duplicated row, two all-zero rows and distinct rows. It then applies responses that hit one row, hit the duplicate pair, hit nothing, and are all zero. A design that stopped at the first match would call the duplicate pair a located fault. One that lacked the zero-response test would report the all-zero rows as an ambiguous group. A second start during a scan and a table write during a scan are both applied. A design that honoured either would change its mask or verdict mid-run or in the next diagnosis. A behavioural model compares every output on every clock, which catches any off-by-one in the done timing and any decay of the results while idle.

// File: rtl/fdiag_pkg.sv
package fdiag_pkg;

  typedef enum logic [1:0] {
    VERD_CLEAN   = 2'd0,
    VERD_LOCATED = 2'd1,
    VERD_AMBIG   = 2'd2,
    VERD_NOMATCH = 2'd3
  } verdict_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SCAN  = 2'd1,
    SQ_FINAL = 2'd2
  } seq_state_e;

  // Outcome from the response being nonzero and the hit tally.
  function automatic verdict_e classify(input logic resp_nonzero,
                                        input logic zero_hits,
                                        input logic one_hit);
    verdict_e v;
    if (!resp_nonzero)  v = VERD_CLEAN;
    else if (zero_hits) v = VERD_NOMATCH;
    else if (one_hit)   v = VERD_LOCATED;
    else                v = VERD_AMBIG;
    return v;
  endfunction

endpackage

// File: rtl/fdiag_table.sv
module fdiag_table #(
  parameter int NUM_FAULTS = 8,
  parameter int NUM_TESTS  = 8,
  localparam int FIDX_W = (NUM_FAULTS > 1) ? $clog2(NUM_FAULTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lock,
  input  logic                 wr_en,
  input  logic [FIDX_W-1:0]    wr_addr,
  input  logic [NUM_TESTS-1:0] wr_row,
  input  logic [FIDX_W-1:0]    rd_addr,
  output logic [NUM_TESTS-1:0] rd_row
);

  logic [NUM_TESTS-1:0] rows_q [NUM_FAULTS];

  for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_row
    logic row_wr_hit;
    assign row_wr_hit = wr_en && !lock && (wr_addr == FIDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rows_q[g] <= '0;
      else if (row_wr_hit) rows_q[g] <= wr_row;
    end

    // R1: rows are frozen while a scan runs
    p_table_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(rows_q[g]));
  end

  assign rd_row = rows_q[rd_addr];

endmodule

// File: rtl/fdiag_seq.sv
module fdiag_seq
  import fdiag_pkg::*;
#(
  parameter int NUM_FAULTS = 8,
  parameter int NUM_TESTS  = 8,
  localparam int FIDX_W = (NUM_FAULTS > 1) ? $clog2(NUM_FAULTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NUM_TESTS-1:0] resp_in,
  output logic                 busy,
  output logic                 accept,
  output logic                 cmp_en,
  output logic [FIDX_W-1:0]    cmp_idx,
  output logic                 finalize,
  output logic                 done,
  output logic [NUM_TESTS-1:0] resp_q
);

  localparam logic [FIDX_W-1:0] LAST_IDX = FIDX_W'(NUM_FAULTS - 1);

  seq_state_e state_q;
  logic       done_q;
  logic       at_last;

  assign at_last  = (cmp_idx == LAST_IDX);
  assign busy     = (state_q != SQ_IDLE);
  assign accept   = (state_q == SQ_IDLE) && start;
  assign cmp_en   = (state_q == SQ_SCAN);
  assign finalize = (state_q == SQ_FINAL);
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cmp_idx <= '0;
      resp_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (start) begin
            resp_q  <= resp_in;
            cmp_idx <= '0;
            state_q <= SQ_SCAN;
          end
        end
        SQ_SCAN: begin
          if (at_last) begin
            cmp_idx <= '0;
            state_q <= SQ_FINAL;
          end else begin
            cmp_idx <= cmp_idx + 1'b1;
          end
        end
        SQ_FINAL: begin
          state_q <= SQ_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R2: an accepted start opens the scan at row 0
  p_accept_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && cmp_en && cmp_idx == '0));
  // R2: done is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: busy only falls together with done
  p_busy_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R3: the captured response is untouched while busy
  p_resp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(resp_q));

endmodule

// File: rtl/fdiag_judge.sv
module fdiag_judge
  import fdiag_pkg::*;
#(
  parameter int NUM_FAULTS = 8,
  parameter int NUM_TESTS  = 8,
  localparam int FIDX_W = (NUM_FAULTS > 1) ? $clog2(NUM_FAULTS) : 1,
  localparam int CNT_W  = $clog2(NUM_FAULTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic                  cmp_en,
  input  logic [FIDX_W-1:0]     cmp_idx,
  input  logic [NUM_TESTS-1:0]  cmp_row,
  input  logic [NUM_TESTS-1:0]  resp_q,
  input  logic                  finalize,
  output logic [NUM_FAULTS-1:0] mask,
  output logic [CNT_W-1:0]      count,
  output verdict_e              verdict,
  output logic [FIDX_W-1:0]     loc_idx
);

  function automatic logic rows_equal(input logic [NUM_TESTS-1:0] a,
                                      input logic [NUM_TESTS-1:0] b);
    return (a ^ b) == '0;
  endfunction

  function automatic logic [FIDX_W-1:0] lowest_set(input logic [NUM_FAULTS-1:0] m);
    logic [FIDX_W-1:0] r;
    logic              found;
    r = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_FAULTS; i++) begin
      if (m[i] && !found) begin
        r = FIDX_W'(i);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  logic     row_hit;
  verdict_e next_verdict;

  assign row_hit      = cmp_en && rows_equal(cmp_row, resp_q);
  assign next_verdict = classify(|resp_q, count == '0, count == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask    <= '0;
      count   <= '0;
      verdict <= VERD_CLEAN;
      loc_idx <= '0;
    end else if (accept) begin
      mask    <= '0;
      count   <= '0;
      verdict <= VERD_CLEAN;
      loc_idx <= '0;
    end else begin
      if (row_hit) begin
        mask[cmp_idx] <= 1'b1;
        count         <= count + 1'b1;
      end
      if (finalize) begin
        verdict <= next_verdict;
        loc_idx <= (next_verdict == VERD_LOCATED) ? lowest_set(mask) : '0;
      end
    end
  end

  // R4: hit tally agrees with the mask
  p_count_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count == CNT_W'($countones(mask)));
  // R5: a located fault is the single marked row
  p_located_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == VERD_LOCATED) |-> (count == CNT_W'(1) && mask[loc_idx]));
  // R6: an ambiguous verdict has several marked rows
  p_ambig_many_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == VERD_AMBIG) |-> (count > CNT_W'(1) && loc_idx == '0));
  // R7: no match means an empty mask
  p_nomatch_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == VERD_NOMATCH) |-> (mask == '0));
  // R8: a zero response always ends clean
  p_zero_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (finalize && resp_q == '0) |=> (verdict == VERD_CLEAN));
  // R9: results hold while nothing drives them
  p_results_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !cmp_en && !finalize) |=> ($stable(mask) && $stable(verdict) && $stable(loc_idx)));

endmodule

// File: rtl/fault_table_diag.sv
module fault_table_diag
  import fdiag_pkg::*;
#(
  parameter int NUM_FAULTS = 8,
  parameter int NUM_TESTS  = 8,
  localparam int FIDX_W = (NUM_FAULTS > 1) ? $clog2(NUM_FAULTS) : 1,
  localparam int CNT_W  = $clog2(NUM_FAULTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tbl_wr_en,
  input  logic [FIDX_W-1:0]     tbl_wr_addr,
  input  logic [NUM_TESTS-1:0]  tbl_wr_row,
  input  logic                  start,
  input  logic [NUM_TESTS-1:0]  response,
  output logic                  busy,
  output logic                  done,
  output logic [1:0]            verdict,
  output logic [FIDX_W-1:0]     located_idx,
  output logic [NUM_FAULTS-1:0] match_mask,
  output logic [CNT_W-1:0]      match_count
);

  logic                 seq_accept;
  logic                 seq_cmp_en;
  logic [FIDX_W-1:0]    seq_cmp_idx;
  logic                 seq_finalize;
  logic [NUM_TESTS-1:0] seq_resp;
  logic [NUM_TESTS-1:0] tbl_rd_row;
  verdict_e             judge_verdict;

  fdiag_seq #(.NUM_FAULTS(NUM_FAULTS), .NUM_TESTS(NUM_TESTS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .resp_in  (response),
    .busy     (busy),
    .accept   (seq_accept),
    .cmp_en   (seq_cmp_en),
    .cmp_idx  (seq_cmp_idx),
    .finalize (seq_finalize),
    .done     (done),
    .resp_q   (seq_resp)
  );

  fdiag_table #(.NUM_FAULTS(NUM_FAULTS), .NUM_TESTS(NUM_TESTS)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock    (busy),
    .wr_en   (tbl_wr_en),
    .wr_addr (tbl_wr_addr),
    .wr_row  (tbl_wr_row),
    .rd_addr (seq_cmp_idx),
    .rd_row  (tbl_rd_row)
  );

  fdiag_judge #(.NUM_FAULTS(NUM_FAULTS), .NUM_TESTS(NUM_TESTS)) u_judge (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (seq_accept),
    .cmp_en   (seq_cmp_en),
    .cmp_idx  (seq_cmp_idx),
    .cmp_row  (tbl_rd_row),
    .resp_q   (seq_resp),
    .finalize (seq_finalize),
    .mask     (match_mask),
    .count    (match_count),
    .verdict  (judge_verdict),
    .loc_idx  (located_idx)
  );

  assign verdict = judge_verdict;

  // R3: a start during a scan does not reset the scan position
  p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && seq_cmp_en && seq_cmp_idx != '0) |=> (seq_cmp_idx != '0 || seq_finalize));

endmodule

// File: tb/fault_table_diag_tb_top.sv
`timescale 1ns/1ps
module fault_table_diag_tb_top;

  localparam int NF = 8;
  localparam int NT = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbl_wr_en = 1'b0;
  logic [2:0] tbl_wr_addr = '0;
  logic [7:0] tbl_wr_row = '0;
  logic       start = 1'b0;
  logic [7:0] response = '0;
  logic       busy, done;
  logic [1:0] verdict;
  logic [2:0] located_idx;
  logic [7:0] match_mask;
  logic [3:0] match_count;

  always #10 clk = ~clk;

  fault_table_diag #(.NUM_FAULTS(NF), .NUM_TESTS(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
    .tbl_wr_row(tbl_wr_row), .start(start), .response(response), .busy(busy),
    .done(done), .verdict(verdict), .located_idx(located_idx),
    .match_mask(match_mask), .match_count(match_count)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_table [NF];
  int m_phase = 0;
  int m_resp = 0, m_mask = 0, m_count = 0, m_verdict = 0, m_idx = 0;
  bit m_done = 0;
  bit m_live = 0;

  always @(posedge clk) begin
    m_done = 0;
    if (!rst_n) begin
      foreach (m_table[i]) m_table[i] = 0;
      m_phase = 0; m_resp = 0; m_mask = 0; m_count = 0; m_verdict = 0; m_idx = 0;
    end else if (m_phase == 0) begin
      if (tbl_wr_en) m_table[tbl_wr_addr] = tbl_wr_row;
      if (start) begin
        m_resp = response; m_mask = 0; m_count = 0; m_verdict = 0; m_idx = 0;
        m_phase = 1;
      end
    end else if (m_phase <= NF) begin
      if (m_table[m_phase-1] == m_resp) begin
        m_mask = m_mask | (1 << (m_phase-1));
        m_count++;
      end
      m_phase++;
    end else begin
      if (m_resp == 0) m_verdict = 0;
      else if (m_count == 0) m_verdict = 3;
      else if (m_count == 1) begin
        m_verdict = 1;
        for (int i = NF-1; i >= 0; i--) if (m_mask[i]) m_idx = i;
      end else m_verdict = 2;
      m_done = 1;
      m_phase = 0;
    end
    m_live = 1;
  end

  always @(negedge clk) begin
    if (m_live && !finished) begin
      chk("R2 busy", busy, m_phase != 0);
      chk("R2 done", done, m_done);
      chk("R4 mask", match_mask, m_mask);
      chk("R4 count", match_count, m_count);
      chk("R9 verdict", verdict, m_verdict);
      chk("R9 located_idx", located_idx, m_idx);
    end
  end

  task automatic write_row(input int a, input int d);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_addr = 3'(a); tbl_wr_row = 8'(d);
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  // Start a diagnosis and wait for done; check the latency.
  task automatic run_diag(input int resp);
    int k;
    @(negedge clk);
    start = 1'b1; response = 8'(resp);
    k = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      k++;
    end while (!done && k < 40);
    chk("R2 latency", k, NF + 2);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 verdict", verdict, 0);
    chk("R10 mask", match_mask, 0);
    chk("R10 count", match_count, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: load the table
    write_row(0, 8'h3A);
    write_row(1, 8'h51);
    write_row(2, 8'h3A);
    write_row(3, 8'h0C);
    write_row(4, 8'h80);
    write_row(5, 8'h00);
    write_row(6, 8'h00);
    write_row(7, 8'hF0);

    // R5: single match
    run_diag(8'h51);
    chk("R5 verdict", verdict, 1);
    chk("R5 located_idx", located_idx, 1);

    // R6: duplicate rows
    run_diag(8'h3A);
    chk("R6 verdict", verdict, 2);
    chk("R6 mask", match_mask, 8'h05);
    chk("R6 located_idx", located_idx, 0);

    // R7: nothing matches
    run_diag(8'h77);
    chk("R7 verdict", verdict, 3);
    chk("R7 mask", match_mask, 0);

    // R8: zero response
    run_diag(8'h00);
    chk("R8 verdict", verdict, 0);
    chk("R8 mask", match_mask, 8'h60);
    chk("R8 count", match_count, 2);

    // R9: results held while idle
    repeat (15) @(negedge clk);
    chk("R9 held verdict", verdict, 0);
    chk("R9 held mask", match_mask, 8'h60);

    // R3 and R1: second start and a write during the scan
    @(negedge clk);
    start = 1'b1; response = 8'h80;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; response = 8'h0C;
    tbl_wr_en = 1'b1; tbl_wr_addr = 3'd4; tbl_wr_row = 8'hAA;
    @(negedge clk);
    start = 1'b0; tbl_wr_en = 1'b0;
    while (!done) @(negedge clk);
    chk("R3 verdict", verdict, 1);
    chk("R3 located_idx", located_idx, 4);
    run_diag(8'h80);
    chk("R1 locked write ignored", located_idx, 4);

    // R1: idle write takes effect
    write_row(7, 8'h51);
    run_diag(8'h51);
    chk("R1 verdict", verdict, 2);
    chk("R1 mask", match_mask, 8'h82);

    // R9: clearing on a new start
    @(negedge clk);
    start = 1'b1; response = 8'h0C;
    @(negedge clk);
    start = 1'b0;
    chk("R9 cleared verdict", verdict, 0);
    chk("R9 cleared mask", match_mask, 0);
    while (!done) @(negedge clk);
    chk("R5 final verdict", verdict, 1);
    chk("R5 final idx", located_idx, 3);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule